// File: doc/BRIEF.md
# FSK Zero-Crossing Interval Demodulator

This block recovers a serial data level from a two-tone frequency-shift-keyed line signal that an external zero-crossing comparator has already squared into one digital input. After a two-flop synchronizer, the input is sampled on a periodic tick. The tick divides the system clock by a parameter. The default of 163 clocks at 50 MHz gives a tick period of about 3.26 µs. An interval counter runs in ticks and measures the spacing of input transitions. Each measured interval is placed in one of five bands. A short interval is a glitch and is absorbed. Two ranges of intervals are errors. One range is the 2100 Hz tone, which decodes to data 0. One range is the 1300 Hz tone, which decodes to data 1.

The recovered bit is meant to drive a UART transmit line directly, so it idles high. A separate activity output is on while the high tone is being received. A one-clock error pulse marks each interval that is rejected. An enable input gates all operation. When the enable is low, the whole block holds still.

Top module: `fsk_interval_demod`

## Requirements
- R1: All counting and edge detection advance only on tick cycles, one tick every `TICK_DIV` clocks. Intervals are measured in ticks, not in clocks.
- R2: While reset is asserted and after it is released, `data_o` is 1, `active_o` is 0 and `err_o` is 0.
- R3: On each tick the interval count is first incremented. Once the incremented count is 95 or more, `data_o` goes to 1 and `active_o` goes to 0, even without an edge. Before the count reaches 95, the outputs keep their values.
- R4: An edge with an incremented count from 40 to 94 decodes the high tone. It drives `data_o` to 0 and `active_o` to 1, and clears the count.
- R5: An edge with a count from 95 to 139 decodes the low tone. It leaves the outputs as the timeout set them, clears the count and raises no error.
- R6: An edge with a count below 20 is a glitch. It changes no output, raises no error and keeps the count running. Only the stored input level is updated.
- R7: An edge with a count from 20 to 39, or 140 or more, is an error. It pulses `err_o` for one clock, leaves `data_o` and `active_o` unchanged and clears the count.
- R8: If the 8-bit count wraps past 255 with no edge, it is cleared and `err_o` pulses. The current input level is stored and no edge is classified on that tick.
- R9: While `en_i` is 0, the count, the stored level, the synchronizer and both data outputs hold their values. Time spent disabled does not add to an interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables operation; the block holds all state while this is low |
| line_i | input | 1 | Squared FSK signal from the zero-crossing comparator |
| data_o | output | 1 | Recovered data level; idles high |
| active_o | output | 1 | High while the high tone is being decoded |
| err_o | output | 1 | One-clock pulse for each rejected interval |

## Verification
A counter that is not cleared after a tone or error decision does not show up at once. It shows up at the next edge, which falls into the wrong band. Either a low-tone interval is turned into a spurious error pulse, or a high-tone interval is missed and `data_o` stays high. Each clearing event is therefore followed by an edge spaced so that the cleared and uncleared cases land in different bands. A glitch that wrongly resets the count is caught in the same way, one interval later, because the following edge then drops into the short error band. A broken freeze or a wrong tick rate shows up within one timeout window (about 95 ticks) as an early high on `data_o`.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;
  typedef enum logic [2:0] {
    BAND_GLITCH,
    BAND_ERR_SHORT,
    BAND_HIGH,
    BAND_LOW,
    BAND_ERR_LONG
  } band_e;
endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int DIV = 163
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  assign tick_o = en_i && (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (en_i)   div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/fsk_sync.sv
module fsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (en_i)  sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/fsk_band_decode.sv
module fsk_band_decode
  import fsk_demod_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int GLITCH_TH = 20,
  parameter int ERR_LO_TH = 40,
  parameter int SPLIT_TH  = 95,
  parameter int ERR_HI_TH = 140
) (
  input  logic [CNT_W-1:0] cnt_i,
  output band_e            band_o
);
  localparam logic [CNT_W-1:0] GL_C = CNT_W'(GLITCH_TH);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(ERR_LO_TH);
  localparam logic [CNT_W-1:0] SP_C = CNT_W'(SPLIT_TH);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(ERR_HI_TH);

  always_comb begin
    if (cnt_i < GL_C)      band_o = BAND_GLITCH;
    else if (cnt_i < LO_C) band_o = BAND_ERR_SHORT;
    else if (cnt_i < SP_C) band_o = BAND_HIGH;
    else if (cnt_i < HI_C) band_o = BAND_LOW;
    else                   band_o = BAND_ERR_LONG;
  end
endmodule

// File: rtl/fsk_interval_core.sv
module fsk_interval_core
  import fsk_demod_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int GLITCH_TH = 20,
  parameter int ERR_LO_TH = 40,
  parameter int SPLIT_TH  = 95,
  parameter int ERR_HI_TH = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  output logic data_o,
  output logic active_o,
  output logic err_o
);
  localparam logic [CNT_W-1:0] SP_C   = CNT_W'(SPLIT_TH);
  localparam logic [CNT_W-1:0] LOM1_C = CNT_W'(ERR_LO_TH - 1);
  localparam logic [CNT_W-1:0] SPM1_C = CNT_W'(SPLIT_TH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_n;
  logic [CNT_W:0]   inc;
  logic             prev_q, prev_d, data_d, act_d, err_d, ovf, step;
  band_e            band;

  assign step  = en_i && tick_i;
  assign inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign ovf   = inc[CNT_W];
  assign cnt_n = inc[CNT_W-1:0];

  fsk_band_decode #(
    .CNT_W(CNT_W), .GLITCH_TH(GLITCH_TH), .ERR_LO_TH(ERR_LO_TH),
    .SPLIT_TH(SPLIT_TH), .ERR_HI_TH(ERR_HI_TH)
  ) u_band (
    .cnt_i (cnt_n),
    .band_o(band)
  );

  always_comb begin
    cnt_d  = cnt_q;
    prev_d = prev_q;
    data_d = data_o;
    act_d  = active_o;
    err_d  = 1'b0;
    if (step) begin
      if (ovf) begin
        cnt_d  = '0;
        prev_d = line_i;
        err_d  = 1'b1;
      end else begin
        cnt_d = cnt_n;
        if (cnt_n >= SP_C) begin  // timeout declares low tone
          data_d = 1'b1;
          act_d  = 1'b0;
        end
        if (line_i != prev_q) begin
          prev_d = line_i;
          case (band)
            BAND_GLITCH: ;        // keep accumulating
            BAND_HIGH: begin
              data_d = 1'b0;
              act_d  = 1'b1;
              cnt_d  = '0;
            end
            BAND_LOW: cnt_d = '0;
            default: begin
              cnt_d = '0;
              err_d = 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      prev_q   <= 1'b0;
      data_o   <= 1'b1;
      active_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      prev_q   <= prev_d;
      data_o   <= data_d;
      active_o <= act_d;
      err_o    <= err_d;
    end
  end

  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(data_o) && $stable(active_o) && $stable(prev_q)));

  assert_err_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cnt_q == '0));

  assert_high_band_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_o) |-> ($past(cnt_q) >= LOM1_C && $past(cnt_q) < SPM1_C));

  assert_rise_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_o) |-> $past(step));
endmodule

// File: rtl/fsk_interval_demod.sv
module fsk_interval_demod #(
  parameter int TICK_DIV    = 163,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int GLITCH_TH   = 20,
  parameter int ERR_LO_TH   = 40,
  parameter int SPLIT_TH    = 95,
  parameter int ERR_HI_TH   = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  output logic data_o,
  output logic active_o,
  output logic err_o
);
  logic tick, line_s;

  fsk_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_o(tick)
  );

  fsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  fsk_interval_core #(
    .CNT_W(CNT_W), .GLITCH_TH(GLITCH_TH), .ERR_LO_TH(ERR_LO_TH),
    .SPLIT_TH(SPLIT_TH), .ERR_HI_TH(ERR_HI_TH)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick),
    .line_i  (line_s),
    .data_o  (data_o),
    .active_o(active_o),
    .err_o   (err_o)
  );
endmodule

// File: tb/fsk_interval_demod_test.sv
module fsk_interval_demod_test;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic line_i = 1'b0;
  logic data_o, active_o, err_o;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fsk_interval_demod #(.TICK_DIV(TDIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .line_i(line_i),
    .data_o(data_o), .active_o(active_o), .err_o(err_o)
  );

  always @(negedge clk) if (err_o) err_seen++;

  task automatic check(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic flip();
    line_i = ~line_i;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R2", data_o, 1, "data in reset");
    check("R2", active_o, 0, "active in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2", data_o, 1, "data after reset");
    check("R2", err_o, 0, "err after reset");
  endtask

  task automatic t_high();
    err_seen = 0;
    for (int i = 0; i < 3; i++) begin
      wait_ticks(60);
      flip();
    end
    wait_ticks(5);
    check("R4", data_o, 0, "data on high tone");
    check("R4", active_o, 1, "active on high tone");
    check("R4", err_seen, 0, "errors on high tone");
  endtask

  task automatic t_timeout();
    wait_ticks(75);
    check("R3", data_o, 0, "data before timeout");
    wait_ticks(20);
    check("R3", data_o, 1, "data after timeout");
    check("R3", active_o, 0, "active after timeout");
  endtask

  task automatic t_low();
    err_seen = 0;
    wait_ticks(15);
    flip();
    wait_ticks(115);
    flip();
    wait_ticks(3);
    check("R5", data_o, 1, "data on low tone");
    wait_ticks(57);
    flip();
    wait_ticks(3);
    check("R5", data_o, 0, "count cleared by low tone");
    check("R5", err_seen, 0, "errors on low tone");
  endtask

  task automatic t_glitch();
    err_seen = 0;
    wait_ticks(115);
    flip();
    wait_ticks(10);
    flip();
    wait_ticks(3);
    check("R1", data_o, 1, "interval counted in ticks");
    check("R6", data_o, 1, "glitch leaves data");
    wait_ticks(29);
    flip();
    wait_ticks(3);
    check("R6", data_o, 0, "count kept across glitch");
    check("R6", err_seen, 0, "no error on glitch");
  endtask

  task automatic t_err_short();
    err_seen = 0;
    wait_ticks(30);
    flip();
    wait_ticks(3);
    check("R7", err_seen, 1, "short interval error pulse");
    check("R7", data_o, 0, "data held on error");
    check("R7", active_o, 1, "active held on error");
    wait_ticks(117);
    flip();
    wait_ticks(3);
    check("R7", err_seen, 1, "count cleared after short error");
    wait_ticks(57);
    flip();
    wait_ticks(3);
  endtask

  task automatic t_err_long();
    err_seen = 0;
    wait_ticks(147);
    flip();
    wait_ticks(3);
    check("R7", err_seen, 1, "long interval error pulse");
    check("R7", data_o, 1, "data after long interval");
    wait_ticks(57);
    flip();
    wait_ticks(3);
    check("R7", data_o, 0, "count cleared after long error");
  endtask

  task automatic t_overflow();
    err_seen = 0;
    wait_ticks(297);
    flip();
    wait_ticks(3);
    check("R8", err_seen, 1, "wrap error pulse");
    check("R8", data_o, 0, "count restarted at wrap");
  endtask

  task automatic t_enable();
    err_seen = 0;
    en_i = 1'b0;
    wait_ticks(100);
    flip();
    wait_ticks(100);
    flip();
    wait_ticks(100);
    check("R9", data_o, 0, "data frozen");
    check("R9", active_o, 1, "active frozen");
    check("R9", err_seen, 0, "no errors while frozen");
    en_i = 1'b1;
    wait_ticks(100);
    check("R9", data_o, 1, "resume after enable");
  endtask

  initial begin
    t_reset();
    t_high();
    t_timeout();
    t_low();
    t_glitch();
    t_err_short();
    t_err_long();
    t_overflow();
    t_enable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule